// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block performs the register side effects of taking an exception in a 32-bit processor core. Each cycle, the pipeline may present one already-prioritised exception: its kind, the PC of the faulting instruction, whether that instruction sits in a branch delay slot, and a few status inputs. The status inputs are the exception-level flag, the bootstrap-vector flag, the vectored-interrupt flag, the exception base and the debug-mode flag. The block then records the correct return address and cause fields, and computes the redirect target.

There are three classes of exception. General exceptions (interrupts, TLB faults, address errors, traps and the rest) write the exception PC and the cause register. Non-maskable interrupts and soft resets write the error return address and head for the boot vector. Debug exceptions write the debug return address and head for the debug vector. The status register itself lives outside this block. The block raises one-cycle strobes that tell the owner of that register which bits to set.

Entry takes one clock. The cycle after an exception is sampled, `redirect` pulses with the new PC, and the updated return-address and cause registers become visible.

Top module: `exc_entry_unit`

## Requirements
- R1: `excKind` with bit 5 clear is a general exception whose cause code is `excKind[4:0]`. One cycle after `excValid` is sampled, `redirect` is high and that code sits in `cause[6:2]`.
- R2: For a general exception with `statusExl` low, `epc` takes `pc`, and `cause[31]` becomes 0. In a delay slot, `epc` takes `pc-4` and `cause[31]` becomes 1. `setExl` and `leaveUser` pulse.
- R3: For a general exception with `statusExl` high, `epc` and `cause[31]` keep their values and `setExl` and `leaveUser` stay low. The cause code is still written.
- R4: A general exception vectors to 0xBFC00200 plus the offset when `statusBev` is high. Otherwise it vectors to `ebase` with bits 9:0 cleared, plus the offset. The default offset is 0x180.
- R5: An interrupt (code 0) with `causeIv` high uses offset 0x200.
- R6: TLB load (code 2), TLB store (code 3) or thread (code 25) with `refillMiss` high and `statusExl` low uses offset 0x000. With `statusExl` high it uses 0x180.
- R7: Coprocessor-unusable (code 11) writes `cpNum` into `cause[29:28]`. Every other exception leaves those bits unchanged.
- R8: Kind 0x20 (NMI) and kind 0x21 (soft reset) write `errorEpc` with `pc`, or `pc-4` in a delay slot. They pulse `setErlBev` and `leaveUser`, plus `setNmi` (NMI) or `setSr` (soft reset). They redirect to 0xBFC00000 and leave `epc` and `cause[6:2]` unchanged.
- R9: Kinds 0x22 to 0x27 (single-step, debug interrupt, instruction break, breakpoint, data break store, data break load) are debug exceptions. They write `depc` with `pc`, or `pc-4` in a delay slot; single-step always uses `pc`. `dbgHit` bit (kind-0x22) pulses. They pulse `enterDebug` and `leaveUser`, and redirect to 0xBFC00480.
- R10: An interrupt (kind 0) taken while `inDebug` is high is handled as a debug interrupt (`dbgHit[1]`, `depc`, 0xBFC00480), and the cause register is untouched.
- R11: NMI, soft reset and debug exceptions clear `cause[31]` when `statusExl` is low, and keep it when `statusExl` is high.
- R12: `redirect` and `clrDelaySlot` pulse together for exactly one cycle per sampled exception. Without `excValid`, neither rises.
- R13: While `rstN` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | An exception is presented this cycle |
| excKind | input | 6 | Exception kind (bit 5 selects the special kinds) |
| pc | input | 32 | PC of the faulting instruction |
| inDelaySlot | input | 1 | Faulting instruction is in a branch delay slot |
| refillMiss | input | 1 | TLB fault was a missing entry |
| cpNum | input | 2 | Coprocessor number for coprocessor-unusable |
| statusExl | input | 1 | Exception level currently set |
| statusBev | input | 1 | Bootstrap vectors selected |
| causeIv | input | 1 | Interrupts use the dedicated vector |
| ebase | input | 32 | Exception vector base |
| inDebug | input | 1 | Core is in debug mode |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| newPc | output | 32 | Redirect target |
| epc | output | 32 | General exception return address |
| errorEpc | output | 32 | Error return address |
| depc | output | 32 | Debug return address |
| cause | output | 32 | Cause register (BD 31, CE 29:28, code 6:2) |
| setExl | output | 1 | Strobe: set exception level |
| setErlBev | output | 1 | Strobe: set error level and bootstrap vectors |
| setNmi | output | 1 | Strobe: record NMI |
| setSr | output | 1 | Strobe: record soft reset |
| enterDebug | output | 1 | Strobe: enter debug mode |
| leaveUser | output | 1 | Strobe: drop to kernel mode |
| clrDelaySlot | output | 1 | Strobe: clear the pipeline delay-slot flag |
| dbgHit | output | 6 | One-hot debug cause strobe |

## Verification
The hardest case is a general exception with the exception level already set. In that case the return address and the delay-slot bit must survive while the code changes. The stimulus first takes a refill fault that leaves a known `epc`. It then presents a second, delay-slot refill fault with `statusExl` high, and checks both the preserved `epc` and the fallback to offset 0x180. The vector table is ordered so that the coprocessor field and the delay-slot bit are set by early rows. Later NMI, soft-reset and debug rows then show whether they keep or clear those fields.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {VEC_GENERAL, VEC_BOOT, VEC_DEBUG} vecSel_e;
  typedef enum logic [1:0] {OFF_COMMON, OFF_IRQ, OFF_REFILL} offSel_e;
  typedef enum logic [1:0] {RET_NONE, RET_EPC, RET_ERR, RET_DBG} retSel_e;

  localparam int KindW   = 6;
  localparam int CodeW   = 5;
  localparam int DbgHitW = 6;

  localparam logic [CodeW-1:0] CODE_INT    = 5'd0;
  localparam logic [CodeW-1:0] CODE_TLBL   = 5'd2;
  localparam logic [CodeW-1:0] CODE_TLBS   = 5'd3;
  localparam logic [CodeW-1:0] CODE_CPU    = 5'd11;
  localparam logic [CodeW-1:0] CODE_THREAD = 5'd25;

  localparam logic [2:0] SPC_NMI    = 3'd0;
  localparam logic [2:0] SPC_SRESET = 3'd1;
  localparam logic [2:0] SPC_SSTEP  = 3'd2;
  localparam logic [2:0] SPC_DBGLO  = 3'd2;
  localparam int         DINT_BIT   = 1;

  typedef struct packed {
    logic               fire;
    retSel_e            retSel;
    logic               useDelay;
    logic               writeCode;
    logic [CodeW-1:0]   code;
    logic               writeBd;
    logic               bdVal;
    logic               writeCe;
    vecSel_e            vecSel;
    offSel_e            offSel;
    logic               setExl;
    logic               setErlBev;
    logic               setNmi;
    logic               setSr;
    logic               enterDebug;
    logic               leaveUser;
    logic [DbgHitW-1:0] dbgHit;
  } ctlStrobes_t;

endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             excValid,
  input  logic [KindW-1:0] excKind,
  input  logic             inDelaySlot,
  input  logic             refillMiss,
  input  logic             statusExl,
  input  logic             causeIv,
  input  logic             inDebug,
  output ctlStrobes_t      ctl
);

  logic             isSpecial;
  logic [2:0]       spc;
  logic [CodeW-1:0] code;
  logic             dintPromote;
  logic             isBoot;
  logic             isRefillKind;
  logic [2:0]       dbgIdx;

  assign isSpecial    = excKind[KindW-1];
  assign spc          = excKind[2:0];
  assign code         = excKind[CodeW-1:0];
  assign dintPromote  = !isSpecial && (code == CODE_INT) && inDebug;
  assign isBoot       = isSpecial && (spc == SPC_NMI || spc == SPC_SRESET);
  assign isRefillKind = (code == CODE_TLBL) || (code == CODE_TLBS) || (code == CODE_THREAD);
  assign dbgIdx       = dintPromote ? 3'(DINT_BIT) : 3'(spc - SPC_DBGLO);

  always_comb begin
    ctl = '0;
    if (excValid) begin
      ctl.fire      = 1'b1;
      ctl.leaveUser = 1'b1;
      if (isSpecial || dintPromote) begin
        ctl.writeBd = !statusExl;
        ctl.bdVal   = 1'b0;
        if (isBoot) begin
          ctl.retSel    = RET_ERR;
          ctl.useDelay  = 1'b1;
          ctl.vecSel    = VEC_BOOT;
          ctl.setErlBev = 1'b1;
          ctl.setNmi    = (spc == SPC_NMI);
          ctl.setSr     = (spc == SPC_SRESET);
        end else begin
          ctl.retSel     = RET_DBG;
          ctl.useDelay   = !(isSpecial && spc == SPC_SSTEP);
          ctl.vecSel     = VEC_DEBUG;
          ctl.enterDebug = 1'b1;
          ctl.dbgHit     = DbgHitW'(1) << dbgIdx;
        end
      end else begin
        ctl.writeCode = 1'b1;
        ctl.code      = code;
        ctl.writeCe   = (code == CODE_CPU);
        ctl.vecSel    = VEC_GENERAL;
        if (code == CODE_INT && causeIv)
          ctl.offSel = OFF_IRQ;
        else if (isRefillKind && refillMiss && !statusExl)
          ctl.offSel = OFF_REFILL;
        else
          ctl.offSel = OFF_COMMON;
        if (!statusExl) begin
          ctl.retSel   = RET_EPC;
          ctl.useDelay = 1'b1;
          ctl.writeBd  = 1'b1;
          ctl.bdVal    = inDelaySlot;
          ctl.setExl   = 1'b1;
        end else begin
          ctl.leaveUser = 1'b0;
        end
      end
    end
  end

  // R3
  exl_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && statusExl) |-> (!ctl.setExl && ctl.retSel != RET_EPC));

  // R10
  dint_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && dintPromote) |-> (!ctl.writeCode && ctl.vecSel == VEC_DEBUG));

endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int            PcW        = 32,
  parameter int            CauseW     = 32,
  parameter int            EbaseAlign = 10,
  parameter int            InstBytes  = 4,
  parameter logic [PcW-1:0] BevGenBase = 32'hBFC0_0200,
  parameter logic [PcW-1:0] BootVec    = 32'hBFC0_0000,
  parameter logic [PcW-1:0] DebugVec   = 32'hBFC0_0480,
  parameter logic [PcW-1:0] OffCommon  = 32'h180,
  parameter logic [PcW-1:0] OffIrq     = 32'h200,
  parameter logic [PcW-1:0] OffRefill  = 32'h000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic [PcW-1:0]     pc,
  input  logic               inDelaySlot,
  input  logic [1:0]         cpNum,
  input  logic               statusBev,
  input  logic [PcW-1:0]     ebase,
  output logic               redirect,
  output logic [PcW-1:0]     newPc,
  output logic [PcW-1:0]     epc,
  output logic [PcW-1:0]     errorEpc,
  output logic [PcW-1:0]     depc,
  output logic [CauseW-1:0]  cause,
  output logic               setExl,
  output logic               setErlBev,
  output logic               setNmi,
  output logic               setSr,
  output logic               enterDebug,
  output logic               leaveUser,
  output logic               clrDelaySlot,
  output logic [DbgHitW-1:0] dbgHit
);

  localparam int CodeLo = 2;
  localparam int CodeHi = CodeLo + CodeW - 1;
  localparam int BdBit  = CauseW - 1;
  localparam int CeLo   = CauseW - 4;
  localparam int CeHi   = CeLo + 1;

  logic [PcW-1:0] retAddr;
  logic [PcW-1:0] genBase;
  logic [PcW-1:0] offset;
  logic [PcW-1:0] target;

  assign retAddr = (ctl.useDelay && inDelaySlot) ? pc - PcW'(InstBytes) : pc;
  assign genBase = statusBev ? BevGenBase : {ebase[PcW-1:EbaseAlign], {EbaseAlign{1'b0}}};

  always_comb begin
    case (ctl.offSel)
      OFF_IRQ:    offset = OffIrq;
      OFF_REFILL: offset = OffRefill;
      default:    offset = OffCommon;
    endcase
    case (ctl.vecSel)
      VEC_BOOT:  target = BootVec;
      VEC_DEBUG: target = DebugVec;
      default:   target = genBase + offset;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirect     <= 1'b0;
      newPc        <= '0;
      epc          <= '0;
      errorEpc     <= '0;
      depc         <= '0;
      cause        <= '0;
      setExl       <= 1'b0;
      setErlBev    <= 1'b0;
      setNmi       <= 1'b0;
      setSr        <= 1'b0;
      enterDebug   <= 1'b0;
      leaveUser    <= 1'b0;
      clrDelaySlot <= 1'b0;
      dbgHit       <= '0;
    end else begin
      redirect     <= ctl.fire;
      clrDelaySlot <= ctl.fire;
      setExl       <= ctl.setExl;
      setErlBev    <= ctl.setErlBev;
      setNmi       <= ctl.setNmi;
      setSr        <= ctl.setSr;
      enterDebug   <= ctl.enterDebug;
      leaveUser    <= ctl.leaveUser;
      dbgHit       <= ctl.dbgHit;
      if (ctl.fire) newPc <= target;
      case (ctl.retSel)
        RET_EPC: epc      <= retAddr;
        RET_ERR: errorEpc <= retAddr;
        RET_DBG: depc     <= retAddr;
        default: ;
      endcase
      if (ctl.writeCode) cause[CodeHi:CodeLo] <= ctl.code;
      if (ctl.writeBd)   cause[BdBit]         <= ctl.bdVal;
      if (ctl.writeCe)   cause[CeHi:CeLo]     <= cpNum;
    end
  end

  // R12
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.fire |=> (!redirect && !clrDelaySlot));

  // R3
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && ctl.retSel != RET_EPC) |=> $stable(epc));

  // R7
  ce_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && !ctl.writeCe) |=> $stable(cause[CeHi:CeLo]));

  // R8
  boot_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    setErlBev |-> (newPc == BootVec && redirect));

  // R9
  debug_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    enterDebug |-> (newPc == DebugVec && redirect));

  // R9
  dbg_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dbgHit));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        excValid,
  input  logic [5:0]  excKind,
  input  logic [31:0] pc,
  input  logic        inDelaySlot,
  input  logic        refillMiss,
  input  logic [1:0]  cpNum,
  input  logic        statusExl,
  input  logic        statusBev,
  input  logic        causeIv,
  input  logic [31:0] ebase,
  input  logic        inDebug,
  output logic        redirect,
  output logic [31:0] newPc,
  output logic [31:0] epc,
  output logic [31:0] errorEpc,
  output logic [31:0] depc,
  output logic [31:0] cause,
  output logic        setExl,
  output logic        setErlBev,
  output logic        setNmi,
  output logic        setSr,
  output logic        enterDebug,
  output logic        leaveUser,
  output logic        clrDelaySlot,
  output logic [5:0]  dbgHit
);

  ctlStrobes_t ctl;

  exc_entry_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .excValid    (excValid),
    .excKind     (excKind),
    .inDelaySlot (inDelaySlot),
    .refillMiss  (refillMiss),
    .statusExl   (statusExl),
    .causeIv     (causeIv),
    .inDebug     (inDebug),
    .ctl         (ctl)
  );

  exc_entry_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .pc           (pc),
    .inDelaySlot  (inDelaySlot),
    .cpNum        (cpNum),
    .statusBev    (statusBev),
    .ebase        (ebase),
    .redirect     (redirect),
    .newPc        (newPc),
    .epc          (epc),
    .errorEpc     (errorEpc),
    .depc         (depc),
    .cause        (cause),
    .setExl       (setExl),
    .setErlBev    (setErlBev),
    .setNmi       (setNmi),
    .setSr        (setSr),
    .enterDebug   (enterDebug),
    .leaveUser    (leaveUser),
    .clrDelaySlot (clrDelaySlot),
    .dbgHit       (dbgHit)
  );

endmodule

// File: tb/exc_entry_unit_test.sv
module exc_entry_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 1'b0;
  logic [5:0]  excKind = '0;
  logic [31:0] pc = '0;
  logic        inDelaySlot = 1'b0;
  logic        refillMiss = 1'b0;
  logic [1:0]  cpNum = '0;
  logic        statusExl = 1'b0;
  logic        statusBev = 1'b0;
  logic        causeIv = 1'b0;
  logic [31:0] ebase = '0;
  logic        inDebug = 1'b0;
  logic        redirect, setExl, setErlBev, setNmi, setSr, enterDebug, leaveUser, clrDelaySlot;
  logic [31:0] newPc, epc, errorEpc, depc, cause;
  logic [5:0]  dbgHit;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  exc_entry_unit uut (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excKind(excKind), .pc(pc),
    .inDelaySlot(inDelaySlot), .refillMiss(refillMiss), .cpNum(cpNum),
    .statusExl(statusExl), .statusBev(statusBev), .causeIv(causeIv), .ebase(ebase),
    .inDebug(inDebug), .redirect(redirect), .newPc(newPc), .epc(epc),
    .errorEpc(errorEpc), .depc(depc), .cause(cause), .setExl(setExl),
    .setErlBev(setErlBev), .setNmi(setNmi), .setSr(setSr), .enterDebug(enterDebug),
    .leaveUser(leaveUser), .clrDelaySlot(clrDelaySlot), .dbgHit(dbgHit)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [5:0]  kind;
    logic [31:0] pcv;
    logic        dly;
    logic        refill;
    logic [1:0]  cp;
    logic        exl;
    logic        bev;
    logic        iv;
    logic        dbgm;
    logic [31:0] ebasev;
    logic [31:0] expPc;
    logic [31:0] expCause;
    logic [1:0]  retSel;
    logic [31:0] expRet;
    logic [5:0]  expFlags;
    logic [5:0]  expDbg;
  } vec_t;

  localparam int NVEC = 14;
  // flags: setExl, setErlBev, setNmi, setSr, enterDebug, leaveUser; retSel 0 epc, 1 errorEpc, 2 depc
  localparam vec_t VECS [NVEC] = '{
    // R1 syscall, BEV vector
    '{4'd1, 6'h08, 32'h8000_1000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,
      32'hBFC0_0380, 32'h0000_0020, 2'd0, 32'h8000_1000, 6'b100001, 6'b0},
    // R2 break in delay slot, EBase vector
    '{4'd2, 6'h09, 32'h8000_2004, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_0000,
      32'h8000_0180, 32'h8000_0024, 2'd0, 32'h8000_2000, 6'b100001, 6'b0},
    // R5 vectored interrupt, EBase low bits dropped
    '{4'd5, 6'h00, 32'h0040_0000, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h8001_2345,
      32'h8001_2200, 32'h0000_0000, 2'd0, 32'h0040_0000, 6'b100001, 6'b0},
    // R6 TLB load refill
    '{4'd6, 6'h02, 32'h0040_0010, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,
      32'hBFC0_0200, 32'h0000_0008, 2'd0, 32'h0040_0010, 6'b100001, 6'b0},
    // R3 TLB store refill with EXL set: epc and BD kept, offset 0x180
    '{4'd3, 6'h03, 32'h0040_0020, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h8000_0000,
      32'h8000_0180, 32'h0000_000C, 2'd0, 32'h0040_0010, 6'b000000, 6'b0},
    // R7 coprocessor unusable, cp 2
    '{4'd7, 6'h0B, 32'h0040_0030, 1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,
      32'hBFC0_0380, 32'h2000_002C, 2'd0, 32'h0040_0030, 6'b100001, 6'b0},
    // R2 overflow in delay slot, CE kept
    '{4'd2, 6'h0C, 32'h0040_0044, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,
      32'hBFC0_0380, 32'hA000_0030, 2'd0, 32'h0040_0040, 6'b100001, 6'b0},
    // R8 NMI in delay slot with EXL set: BD kept
    '{4'd8, 6'h20, 32'h0040_0050, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,
      32'hBFC0_0000, 32'hA000_0030, 2'd1, 32'h0040_004C, 6'b011001, 6'b0},
    // R11 soft reset with EXL clear: BD cleared
    '{4'd11, 6'h21, 32'h0040_0060, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,
      32'hBFC0_0000, 32'h2000_0030, 2'd1, 32'h0040_0060, 6'b010101, 6'b0},
    // R9 single step in delay slot uses pc
    '{4'd9, 6'h22, 32'h0040_0074, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,
      32'hBFC0_0480, 32'h2000_0030, 2'd2, 32'h0040_0074, 6'b000011, 6'b000001},
    // R9 breakpoint in delay slot uses pc-4
    '{4'd9, 6'h25, 32'h0040_0084, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,
      32'hBFC0_0480, 32'h2000_0030, 2'd2, 32'h0040_0080, 6'b000011, 6'b001000},
    // R10 interrupt in debug mode
    '{4'd10, 6'h00, 32'h0040_0090, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0,
      32'hBFC0_0480, 32'h2000_0030, 2'd2, 32'h0040_0090, 6'b000011, 6'b000010},
    // R6 thread refill
    '{4'd6, 6'h19, 32'h0040_00A0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,
      32'hBFC0_0200, 32'h2000_0064, 2'd0, 32'h0040_00A0, 6'b100001, 6'b0},
    // R4 EBase all ones
    '{4'd4, 6'h07, 32'h0040_00B0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF,
      32'hFFFF_FD80, 32'h2000_001C, 2'd0, 32'h0040_00B0, 6'b100001, 6'b0}
  };

  task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R12 watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] ret;
    logic [5:0]  flags;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("redirect in reset", 13, 32'(redirect), 32'd0);
    check("newPc in reset", 13, newPc, 32'd0);
    check("cause in reset", 13, cause, 32'd0);
    check("epc in reset", 13, epc, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R12 idle: no redirect
    check("idle redirect", 12, 32'(redirect), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      excKind     = VECS[i].kind;
      pc          = VECS[i].pcv;
      inDelaySlot = VECS[i].dly;
      refillMiss  = VECS[i].refill;
      cpNum       = VECS[i].cp;
      statusExl   = VECS[i].exl;
      statusBev   = VECS[i].bev;
      causeIv     = VECS[i].iv;
      inDebug     = VECS[i].dbgm;
      ebase       = VECS[i].ebasev;
      excValid    = 1'b1;
      @(negedge clk);
      excValid = 1'b0;
      ret = (VECS[i].retSel == 2'd0) ? epc : (VECS[i].retSel == 2'd1) ? errorEpc : depc;
      flags = {setExl, setErlBev, setNmi, setSr, enterDebug, leaveUser};
      check("redirect", 12, 32'(redirect), 32'd1);
      check("clrDelaySlot", 12, 32'(clrDelaySlot), 32'd1);
      check("newPc", int'(VECS[i].req), newPc, VECS[i].expPc);
      check("cause", int'(VECS[i].req), cause, VECS[i].expCause);
      check("return address", int'(VECS[i].req), ret, VECS[i].expRet);
      check("status strobes", int'(VECS[i].req), 32'(flags), 32'(VECS[i].expFlags));
      check("dbgHit", int'(VECS[i].req), 32'(dbgHit), 32'(VECS[i].expDbg));
      @(negedge clk);
      // R12 single-cycle pulse
      check("redirect pulse end", 12, 32'(redirect), 32'd0);
      check("clrDelaySlot pulse end", 12, 32'(clrDelaySlot), 32'd0);
    end

    // R8 NMI leaves epc and code alone
    check("epc after specials", 8, epc, 32'h0040_00B0);

    // R12 inputs toggling without excValid change nothing
    excKind = 6'h0B; cpNum = 2'd3; pc = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("no valid redirect", 12, 32'(redirect), 32'd0);
    check("no valid cause", 12, cause, 32'h2000_001C);

    // R13 reset mid-run clears state
    rstN = 1'b0;
    @(negedge clk);
    check("epc after reset", 13, epc, 32'd0);
    check("depc after reset", 13, depc, 32'd0);
    check("cause after reset", 13, cause, 32'd0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule